// File: doc/BRIEF.md
# Adaptive Interrupt Pacing Timer

This block limits how often the receive and transmit interrupt pulses may reach the processor. A shared prescaler turns a slow clock enable into a fixed time tick. The ticks are grouped into measurement intervals. During each interval, each channel counts the pulses it let through. At the end of the interval, that count is compared with a programmed target rate. The comparison then lengthens or shortens the channel's hold-off length by one tick.

After a pulse is issued, a per-channel countdown timer is loaded with the hold-off length. While the timer is non-zero, the channel's permit output is low and further requests are blocked. Heavy traffic therefore pushes the hold-off window longer, and light traffic lets it shrink back. A target of zero turns pacing off for that channel.

With the default parameters, an enable at one sixth of the core clock and a prescale value equal to the number of enables in 4 µs give a 4 µs tick and a 1 ms interval of 250 ticks.

Top module: `irq_pacer`

## Requirements
- R1: `tick` is high for one cycle on every `prescale`-th cycle in which `clk_en` is high, and never when `clk_en` is low. A `prescale` of 0 behaves as 1.
- R2: `ivl_end` is high together with every `TICKS_PER_IVL`-th tick after reset, and at no other time.
- R3: A channel's permit output is high exactly when its countdown timer is zero or its target is zero. Its pulse output is its request ANDed with its permit in the same cycle.
- R4: Each issued pulse loads the channel's timer with its hold-off length. After that, the timer drops by one on each tick until it reaches zero.
- R5: On an `ivl_end` cycle, a channel whose interval count is above its target gains one tick of hold-off length, saturating at `LEN_MAX`. A count below the target loses one tick, saturating at 0. An equal count leaves the length unchanged. The new length is visible on the following cycle.
- R6: The interval count holds the pulses issued since the last interval end, saturating at its maximum. A pulse issued in the `ivl_end` cycle itself is counted in the next interval.
- R7: While a channel's target is zero, its permit stays high, and its hold-off length and timer are held at zero.
- R8: The receive and transmit channels have independent targets, counts, timers and lengths, and share one tick.
- R9: After reset, both permits are high, both hold-off lengths are zero and the prescaler starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Slow enable that the prescaler counts |
| prescale | input | PRESC_W | Number of enables per tick |
| rx_target | input | EVT_W | Receive pulses allowed per interval, 0 disables pacing |
| tx_target | input | EVT_W | Transmit pulses allowed per interval, 0 disables pacing |
| rx_req | input | 1 | Raw receive interrupt request |
| tx_req | input | 1 | Raw transmit interrupt request |
| tick | output | 1 | Prescaled time tick |
| ivl_end | output | 1 | Last tick of a measurement interval |
| rx_pulse | output | 1 | Paced receive interrupt pulse |
| tx_pulse | output | 1 | Paced transmit interrupt pulse |
| rx_permit | output | 1 | Receive channel not blocked |
| tx_permit | output | 1 | Transmit channel not blocked |
| rx_hold | output | LEN_W | Current receive hold-off length in ticks |
| tx_hold | output | LEN_W | Current transmit hold-off length in ticks |

## Verification
The bench drives continuous demand against a target of one, so the transmit length climbs into its ceiling. A design that fails to saturate there would wrap back to zero. A large target then drags the length back to the floor, where an unclamped decrement would wrap to the maximum. A stretch with a gated `clk_en` and sparse requests catches a prescaler that counts clock cycles instead of enables. It also catches a pulse in the interval-end cycle being counted in the wrong interval, which shows up as a one-tick length error. A receive target of zero, held while the transmit channel is busy, exposes any state shared between the channels or a permit that drops when pacing is off.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;

  typedef enum logic [1:0] {
    RATE_BELOW = 2'd0,
    RATE_EQUAL = 2'd1,
    RATE_ABOVE = 2'd2
  } rate_cmp_e;

  // Relation of the pulses seen in an interval to the goal rate.
  function automatic rate_cmp_e rate_compare(input int unsigned seen,
                                             input int unsigned goal);
    if (seen > goal) return RATE_ABOVE;
    if (seen < goal) return RATE_BELOW;
    return RATE_EQUAL;
  endfunction

endpackage

// File: rtl/pacer_tick_gen.sv
module pacer_tick_gen #(
  parameter int PRESC_W       = 16,
  parameter int TICKS_PER_IVL = 250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en,
  input  logic [PRESC_W-1:0] prescale,
  output logic               tick,
  output logic               ivl_end
);
  localparam int IVL_W = $clog2(TICKS_PER_IVL + 1);

  logic [PRESC_W-1:0] presc_cnt;
  logic [IVL_W-1:0]   ivl_cnt;

  // True when the current enable closes a prescale period (0 acts as 1).
  function automatic logic presc_last(input logic [PRESC_W-1:0] cnt,
                                      input logic [PRESC_W-1:0] lim);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, lim};
  endfunction

  assign tick    = clk_en && presc_last(presc_cnt, prescale);
  assign ivl_end = tick && (ivl_cnt == IVL_W'(TICKS_PER_IVL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_cnt <= '0;
      ivl_cnt   <= '0;
    end else begin
      if (tick)        presc_cnt <= '0;
      else if (clk_en) presc_cnt <= presc_cnt + 1'b1;
      if (ivl_end)     ivl_cnt <= '0;
      else if (tick)   ivl_cnt <= ivl_cnt + 1'b1;
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || prescale <= PRESC_W'(1)));

  // R2
  ivl_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_end |=> (!ivl_end || TICKS_PER_IVL == 1));

endmodule

// File: rtl/pacer_channel.sv
module pacer_channel
  import irq_pacer_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int LEN_MAX = 255,
  parameter int EVT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ivl_end,
  input  logic             req,
  input  logic [EVT_W-1:0] target,
  output logic             pulse,
  output logic             permit,
  output logic [LEN_W-1:0] hold_len
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(LEN_MAX);
  localparam logic [EVT_W-1:0] EVT_CAP = '1;

  logic [LEN_W-1:0] timer;
  logic [EVT_W-1:0] evt_cnt;
  logic             pacing_off;
  logic             reload;
  logic             countdown;
  rate_cmp_e        verdict;

  function automatic logic [LEN_W-1:0] step_len(input logic [LEN_W-1:0] cur,
                                                input rate_cmp_e how);
    case (how)
      RATE_ABOVE: return (cur < LEN_CAP) ? cur + 1'b1 : cur;
      RATE_BELOW: return (cur != '0) ? cur - 1'b1 : cur;
      default:    return cur;
    endcase
  endfunction

  function automatic logic [EVT_W-1:0] count_up(input logic [EVT_W-1:0] cur);
    return (cur == EVT_CAP) ? cur : cur + 1'b1;
  endfunction

  assign pacing_off = (target == '0);
  assign permit     = pacing_off || (timer == '0);
  assign pulse      = req && permit;
  assign reload     = pulse && !pacing_off;
  assign countdown  = tick && (timer != '0);
  assign verdict    = rate_compare(int'(evt_cnt), int'(target));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer    <= '0;
      evt_cnt  <= '0;
      hold_len <= '0;
    end else begin
      if (pacing_off)     timer <= '0;
      else if (reload)    timer <= hold_len;
      else if (countdown) timer <= timer - 1'b1;

      if (ivl_end)    evt_cnt <= pulse ? EVT_W'(1) : '0;
      else if (pulse) evt_cnt <= count_up(evt_cnt);

      if (pacing_off)   hold_len <= '0;
      else if (ivl_end) hold_len <= step_len(hold_len, verdict);
    end
  end

  // R4
  reload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> timer == $past(hold_len));

  // R5
  hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl_end && !pacing_off) |=> (hold_len == $past(hold_len) ||
      hold_len == $past(hold_len) + 1'b1 || hold_len + 1'b1 == $past(hold_len)));

  // R5
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ivl_end && !pacing_off) |=> hold_len == $past(hold_len));

  // R5
  hold_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_len <= LEN_CAP);

  // R7
  pacing_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pacing_off |=> (timer == '0 && hold_len == '0));

endmodule

// File: rtl/irq_pacer.sv
module irq_pacer #(
  parameter int PRESC_W       = 16,
  parameter int TICKS_PER_IVL = 250,
  parameter int LEN_W         = 8,
  parameter int LEN_MAX       = 255,
  parameter int EVT_W         = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en,
  input  logic [PRESC_W-1:0] prescale,
  input  logic [EVT_W-1:0]   rx_target,
  input  logic [EVT_W-1:0]   tx_target,
  input  logic               rx_req,
  input  logic               tx_req,
  output logic               tick,
  output logic               ivl_end,
  output logic               rx_pulse,
  output logic               tx_pulse,
  output logic               rx_permit,
  output logic               tx_permit,
  output logic [LEN_W-1:0]   rx_hold,
  output logic [LEN_W-1:0]   tx_hold
);
  localparam int NCH = 2;

  logic [EVT_W-1:0] ch_target [NCH];
  logic             ch_req    [NCH];
  logic             ch_pulse  [NCH];
  logic             ch_permit [NCH];
  logic [LEN_W-1:0] ch_hold   [NCH];

  assign ch_target[0] = rx_target;
  assign ch_target[1] = tx_target;
  assign ch_req[0]    = rx_req;
  assign ch_req[1]    = tx_req;

  pacer_tick_gen #(
    .PRESC_W      (PRESC_W),
    .TICKS_PER_IVL(TICKS_PER_IVL)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .prescale(prescale),
    .tick    (tick),
    .ivl_end (ivl_end)
  );

  // R8: one independent channel per interrupt class, sharing the tick.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pacer_channel #(
      .LEN_W  (LEN_W),
      .LEN_MAX(LEN_MAX),
      .EVT_W  (EVT_W)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .ivl_end (ivl_end),
      .req     (ch_req[ch]),
      .target  (ch_target[ch]),
      .pulse   (ch_pulse[ch]),
      .permit  (ch_permit[ch]),
      .hold_len(ch_hold[ch])
    );
  end

  assign rx_pulse  = ch_pulse[0];
  assign tx_pulse  = ch_pulse[1];
  assign rx_permit = ch_permit[0];
  assign tx_permit = ch_permit[1];
  assign rx_hold   = ch_hold[0];
  assign tx_hold   = ch_hold[1];

endmodule

// File: tb/test_irq_pacer.sv
module test_irq_pacer;
  localparam int P   = 3;
  localparam int T   = 10;
  localparam int LM  = 7;
  localparam int EW  = 8;
  localparam int LW  = 8;
  localparam int PW  = 16;

  logic clk = 0, rst_n = 0, clk_en = 0;
  logic [PW-1:0] prescale = PW'(P);
  logic [EW-1:0] rx_target = 0, tx_target = 0;
  logic rx_req = 0, tx_req = 0;
  logic tick, ivl_end, rx_pulse, tx_pulse, rx_permit, tx_permit;
  logic [LW-1:0] rx_hold, tx_hold;

  always #10 clk = ~clk;

  irq_pacer #(.PRESC_W(PW), .TICKS_PER_IVL(T), .LEN_W(LW), .LEN_MAX(LM), .EVT_W(EW))
  i_irq_pacer (.clk(clk), .rst_n(rst_n), .clk_en(clk_en), .prescale(prescale),
    .rx_target(rx_target), .tx_target(tx_target), .rx_req(rx_req), .tx_req(tx_req),
    .tick(tick), .ivl_end(ivl_end), .rx_pulse(rx_pulse), .tx_pulse(tx_pulse),
    .rx_permit(rx_permit), .tx_permit(tx_permit), .rx_hold(rx_hold), .tx_hold(tx_hold));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Reference model state, advanced at each rising edge.
  typedef struct { int rx; int tx; } hold_pair_t;
  hold_pair_t exp_q[$];
  int m_en_cnt = 0, m_tick_cnt = 0;
  int m_tmr[2], m_hold[2], m_evt[2];

  function automatic bit m_tick_now();
    return clk_en && (m_en_cnt == P - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en_cnt = 0; m_tick_cnt = 0;
      for (int c = 0; c < 2; c++) begin m_tmr[c] = 0; m_hold[c] = 0; m_evt[c] = 0; end
    end else begin
      bit t, iv;
      t  = m_tick_now();
      iv = t && (m_tick_cnt == T - 1);
      m_en_cnt   = t ? 0 : (clk_en ? m_en_cnt + 1 : m_en_cnt);
      m_tick_cnt = iv ? 0 : (t ? m_tick_cnt + 1 : m_tick_cnt);
      for (int c = 0; c < 2; c++) begin
        int tg, nh;
        bit rq, pl;
        tg = (c == 0) ? int'(rx_target) : int'(tx_target);
        rq = (c == 0) ? rx_req : tx_req;
        pl = rq && (tg == 0 || m_tmr[c] == 0);
        nh = m_hold[c];
        if (iv && m_evt[c] > tg && nh < LM) nh++;
        if (iv && m_evt[c] < tg && nh > 0) nh--;
        if (tg == 0) begin m_tmr[c] = 0; nh = 0; end
        else if (pl) m_tmr[c] = m_hold[c];
        else if (t && m_tmr[c] > 0) m_tmr[c]--;
        if (iv) m_evt[c] = pl ? 1 : 0;
        else if (pl && m_evt[c] < 255) m_evt[c]++;
        m_hold[c] = nh;
      end
      if (iv) exp_q.push_back('{rx: m_hold[0], tx: m_hold[1]});
    end
  end

  // Monitor: compares every cycle away from the edge and drains the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit t, iv, pr, pt;
      t  = m_tick_now();
      iv = t && (m_tick_cnt == T - 1);
      pr = (rx_target == 0) || (m_tmr[0] == 0);
      pt = (tx_target == 0) || (m_tmr[1] == 0);
      chk("R1 tick", int'(tick), int'(t));
      chk("R2 ivl_end", int'(ivl_end), int'(iv));
      chk("R3 rx_permit", int'(rx_permit), int'(pr));
      chk("R3 tx_permit", int'(tx_permit), int'(pt));
      chk("R4 rx_pulse", int'(rx_pulse), int'(rx_req && pr));
      chk("R4 tx_pulse", int'(tx_pulse), int'(tx_req && pt));
      while (exp_q.size() > 0) begin
        hold_pair_t e;
        e = exp_q.pop_front();
        chk("R5 R6 rx_hold", int'(rx_hold), e.rx);
        chk("R5 R6 tx_hold", int'(tx_hold), e.tx);
      end
    end
  end

  task automatic drive_cycles(input int n, input int en_mod, input int rx_mod, input int tx_mod);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      clk_en = (i % en_mod) == 0;
      rx_req = (i % rx_mod) == 0;
      tx_req = (i % tx_mod) == 0;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 rx_permit", int'(rx_permit), 1);
    chk("R9 tx_permit", int'(tx_permit), 1);
    chk("R9 rx_hold", int'(rx_hold), 0);
    chk("R9 tx_hold", int'(tx_hold), 0);
    chk("R9 tick", int'(tick), 0);
    @(posedge clk); #2;
    rst_n = 1; clk_en = 1;

    // R5 climb to ceiling on tx, R7 rx pacing off, R8 independence
    rx_target = 0; tx_target = 1;
    drive_cycles(12 * P * T, 1, 1, 1);
    @(negedge clk);
    chk("R5 tx_hold at ceiling", int'(tx_hold), LM);
    chk("R7 rx_hold with target 0", int'(rx_hold), 0);
    chk("R7 rx_permit with target 0", int'(rx_permit), 1);
    chk("R8 rx_pulse unaffected by tx", int'(rx_pulse), int'(rx_req));

    // R5 fall to floor with a large target
    tx_target = 200; rx_target = 2;
    drive_cycles(10 * P * T, 1, 4, 1);
    @(negedge clk);
    chk("R5 tx_hold at floor", int'(tx_hold), 0);

    // R1 gated enable, R6 sparse requests straddling interval ends
    rx_target = 2; tx_target = 3;
    drive_cycles(10 * 2 * P * T, 2, 5, 7);
    drive_cycles(8 * P * T, 1, 13, 11);

    // R7 pacing switched off on tx after it was active
    tx_target = 1;
    drive_cycles(4 * P * T, 1, 1, 1);
    tx_target = 0;
    drive_cycles(2, 1, 1, 1);
    @(negedge clk);
    chk("R7 tx_hold cleared", int'(tx_hold), 0);
    chk("R7 tx_permit high", int'(tx_permit), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule